// File: doc/BRIEF.md
# PCI Slot Hotplug Event Controller

This block tells platform firmware when a device has been hot-inserted into or hot-removed from one of 32 PCI slots. A hotplug event strobe carries a slot number and a kind (cold, insert or remove). For an insert or remove event, the block records which slot changed in one of two 32-bit slot registers. It also raises a hotplug flag in a 16-bit general-purpose-event status register. When that flag is enabled, the block drives a pending line to the system interrupt logic.

Firmware reaches the block over a simple I/O bus. The bus has a write strobe, an address and write data, and it returns read data combinationally. Through this bus firmware can do the following:
- read the event status and enable registers, one byte at a time;
- clear event status bits, byte by byte, by writing ones;
- read and write the insert and remove registers;
- request an eject by writing a slot bitmap;
- read a removability mask.

The mask reads as all ones, except for the slots that the system marks as fixed. When firmware requests an eject, the block emits a one-cycle eject strobe together with a slot number, which the platform uses to tear the device down.

Top module: `hp_event_ctrl`

## Requirements
- R1: After a synchronous reset, the event status, event enable, insert and remove registers all read 0, `gpe_pending` is low and `eject_pulse` is low.
- R2: The event registers are byte ports at these addresses: status low byte at 0x00, status high byte at 0x01, enable low byte at 0x02, enable high byte at 0x03. A read of a byte port returns that byte in `io_rdata[7:0]`, with bits 31:8 at zero.
- R3: A write to an enable byte port replaces that byte with `io_wdata[7:0]` and leaves the other enable byte unchanged.
- R4: A write to a status byte port clears each bit of that byte for which `io_wdata[7:0]` has a one. The other bits of that byte and the other status byte are unchanged.
- R5: A hot-insert event (`evt_kind` = 2'b01) clears both slot registers, then sets bit `evt_slot` of the insert register, and sets status bit 1. All of this is visible after the next clock edge.
- R6: A hot-remove event (`evt_kind` = 2'b10) clears both slot registers, then sets bit `evt_slot` of the remove register, and sets status bit 1.
- R7: A cold-plug event (`evt_kind` = 2'b00) and the reserved kind 2'b11 change no register and raise no status.
- R8: `gpe_pending` is high exactly when status bit 1 and enable bit 1 are both set.
- R9: The insert register at 0x08 and the remove register at 0x0C are 32-bit registers that software can read and write.
- R10: When a nonzero value is written to the eject port at 0x10, `eject_pulse` is high for exactly the one cycle after the write edge. During that cycle `eject_slot` holds the index of the lowest set bit of the written value. Writing zero produces no pulse, and reads of 0x10 return 0.
- R11: The removability register at 0x14 reads as the bitwise inverse of `fixed_mask`, and writes to it have no effect.
- R12: If a hot event and a software write occur in the same cycle, the event wins. The slot registers take the event's value, and status bit 1 ends up set even if the same write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Hotplug event strobe |
| evt_kind | input | 2 | 00 cold, 01 insert, 10 remove, 11 reserved |
| evt_slot | input | 5 | Slot number of the event |
| fixed_mask | input | 32 | One bit per slot that is not hot-pluggable |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 5 | I/O address |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data (combinational) |
| gpe_pending | output | 1 | Enabled hotplug event pending |
| eject_pulse | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot to eject, valid with eject_pulse |

## Verification
The event path is driven with inserts and removes on the first slot, the last slot and a middle slot. This shows whether a new event wipes the bit left behind by the previous one, including a bit in the other register. Status clearing is tried with several byte patterns: clearing the hotplug bit, writing zeros, and writing ones to the high byte. These tell a per-byte write-1-to-clear apart from a plain overwrite, and from a write that spills into the other byte. Eject is driven with single-bit values, multi-bit values and zero. This separates lowest-bit selection from highest-bit selection, and shows whether a zero write is suppressed. A same-cycle event-plus-write case shows which side has priority.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int SLOTS   = 32;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int ADDR_W  = 5;
    localparam int GPE_W   = 16;
    localparam int HP_BIT  = 1;

    localparam logic [ADDR_W-1:0] A_STS_LO = 5'h00;
    localparam logic [ADDR_W-1:0] A_STS_HI = 5'h01;
    localparam logic [ADDR_W-1:0] A_EN_LO  = 5'h02;
    localparam logic [ADDR_W-1:0] A_EN_HI  = 5'h03;
    localparam logic [ADDR_W-1:0] A_INS    = 5'h08;
    localparam logic [ADDR_W-1:0] A_REM    = 5'h0C;
    localparam logic [ADDR_W-1:0] A_EJECT  = 5'h10;
    localparam logic [ADDR_W-1:0] A_RMV    = 5'h14;

    typedef enum logic [1:0] {
        EV_COLD   = 2'b00,
        EV_INSERT = 2'b01,
        EV_REMOVE = 2'b10,
        EV_RSVD   = 2'b11
    } ev_kind_e;

    typedef struct packed {
        logic              valid;
        ev_kind_e          kind;
        logic [SLOT_W-1:0] slot;
    } hp_evt_t;

    // Index of the lowest set bit; 0 when no bit is set.
    function automatic logic [SLOT_W-1:0] lowest_set(input logic [SLOTS-1:0] v);
        logic [SLOT_W-1:0] idx;
        idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (v[i]) idx = SLOT_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wbyte,
    input  logic              set_hp,
    output logic [GPE_W-1:0]  sts,
    output logic [GPE_W-1:0]  en
);
    logic [GPE_W-1:0] sts_n;
    logic [GPE_W-1:0] en_n;

    always_comb begin
        sts_n = sts;
        en_n  = en;
        if (wr) begin
            case (addr)
                A_STS_LO: sts_n[7:0]  = sts[7:0]  & ~wbyte;
                A_STS_HI: sts_n[15:8] = sts[15:8] & ~wbyte;
                A_EN_LO:  en_n[7:0]   = wbyte;
                A_EN_HI:  en_n[15:8]  = wbyte;
                default: ;
            endcase
        end
        // A new event overrides a same-cycle clear.
        if (set_hp) sts_n[HP_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= sts_n;
            en  <= en_n;
        end
    end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SLOTS-1:0]  wdata,
    input  hp_evt_t           evt,
    output logic [SLOTS-1:0]  ins,
    output logic [SLOTS-1:0]  rem
);
    logic [SLOTS-1:0] ins_n;
    logic [SLOTS-1:0] rem_n;

    always_comb begin
        ins_n = ins;
        rem_n = rem;
        if (wr && addr == A_INS) ins_n = wdata;
        if (wr && addr == A_REM) rem_n = wdata;
        if (evt.valid) begin
            case (evt.kind)
                EV_INSERT: begin
                    ins_n = '0;
                    rem_n = '0;
                    ins_n[evt.slot] = 1'b1;
                end
                EV_REMOVE: begin
                    ins_n = '0;
                    rem_n = '0;
                    rem_n[evt.slot] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins <= '0;
            rem <= '0;
        end else begin
            ins <= ins_n;
            rem <= rem_n;
        end
    end
endmodule

// File: rtl/hp_eject.sv
module hp_eject
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SLOTS-1:0]  wdata,
    output logic              pulse,
    output logic [SLOT_W-1:0] slot
);
    logic req;
    assign req = wr && (addr == A_EJECT) && (|wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
            slot  <= '0;
        end else begin
            pulse <= req;
            if (req) slot <= lowest_set(wdata);
        end
    end
endmodule

// File: rtl/hp_event_ctrl.sv
module hp_event_ctrl
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [SLOT_W-1:0] evt_slot,
    input  logic [SLOTS-1:0]  fixed_mask,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [SLOTS-1:0]  io_wdata,
    output logic [SLOTS-1:0]  io_rdata,
    output logic              gpe_pending,
    output logic              eject_pulse,
    output logic [SLOT_W-1:0] eject_slot
);
    hp_evt_t          evt;
    logic             hot;
    logic [GPE_W-1:0] gpe_sts;
    logic [GPE_W-1:0] gpe_en;
    logic [SLOTS-1:0] ins_q;
    logic [SLOTS-1:0] rem_q;

    assign evt.valid = evt_valid;
    assign evt.kind  = ev_kind_e'(evt_kind);
    assign evt.slot  = evt_slot;
    assign hot = evt.valid && (evt.kind == EV_INSERT || evt.kind == EV_REMOVE);

    hp_gpe_regs u_gpe (
        .clk    (clk),
        .rst    (rst),
        .wr     (io_wr),
        .addr   (io_addr),
        .wbyte  (io_wdata[7:0]),
        .set_hp (hot),
        .sts    (gpe_sts),
        .en     (gpe_en)
    );

    hp_slot_regs u_slots (
        .clk   (clk),
        .rst   (rst),
        .wr    (io_wr),
        .addr  (io_addr),
        .wdata (io_wdata),
        .evt   (evt),
        .ins   (ins_q),
        .rem   (rem_q)
    );

    hp_eject u_eject (
        .clk   (clk),
        .rst   (rst),
        .wr    (io_wr),
        .addr  (io_addr),
        .wdata (io_wdata),
        .pulse (eject_pulse),
        .slot  (eject_slot)
    );

    assign gpe_pending = gpe_sts[HP_BIT] & gpe_en[HP_BIT];

    always_comb begin
        io_rdata = '0;
        case (io_addr)
            A_STS_LO: io_rdata[7:0] = gpe_sts[7:0];
            A_STS_HI: io_rdata[7:0] = gpe_sts[15:8];
            A_EN_LO:  io_rdata[7:0] = gpe_en[7:0];
            A_EN_HI:  io_rdata[7:0] = gpe_en[15:8];
            A_INS:    io_rdata = ins_q;
            A_REM:    io_rdata = rem_q;
            A_RMV:    io_rdata = ~fixed_mask;
            default:  io_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hp_event_ctrl_chk.sv
module hp_event_ctrl_chk
    import hp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              evt_valid,
    input logic [1:0]        evt_kind,
    input logic [SLOT_W-1:0] evt_slot,
    input logic [SLOTS-1:0]  fixed_mask,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic [SLOTS-1:0]  io_wdata,
    input logic [SLOTS-1:0]  io_rdata,
    input logic              gpe_pending,
    input logic              eject_pulse,
    input logic [GPE_W-1:0]  gpe_sts,
    input logic [GPE_W-1:0]  gpe_en,
    input logic [SLOTS-1:0]  ins_q,
    input logic [SLOTS-1:0]  rem_q
);
    p_insert_r5: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_kind == 2'b01) |=>
            (ins_q == (SLOTS'(1) << $past(evt_slot))) && (rem_q == '0) && gpe_sts[HP_BIT]);

    p_remove_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_kind == 2'b10) |=>
            (rem_q == (SLOTS'(1) << $past(evt_slot))) && (ins_q == '0) && gpe_sts[HP_BIT]);

    p_cold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!io_wr && (!evt_valid || evt_kind == 2'b00 || evt_kind == 2'b11)) |=>
            ($stable(ins_q) && $stable(rem_q) && $stable(gpe_sts) && $stable(gpe_en)));

    p_pending_r8: assert property (@(posedge clk) disable iff (rst)
        gpe_pending |-> (gpe_sts[HP_BIT] && gpe_en[HP_BIT]));

    p_eject_cause_r10: assert property (@(posedge clk) disable iff (rst)
        eject_pulse |-> $past(io_wr && io_addr == A_EJECT && io_wdata != '0));

    p_eject_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == A_EJECT && io_wdata == '0) |=> !eject_pulse);

    p_rmv_read_r11: assert property (@(posedge clk) disable iff (rst)
        (io_addr == A_RMV) |-> (io_rdata == ~fixed_mask));
endmodule

bind hp_event_ctrl hp_event_ctrl_chk u_chk (.*);

// File: tb/hp_event_ctrl_tb.sv
module hp_event_ctrl_tb;
    import hp_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              evt_valid = 1'b0;
    logic [1:0]        evt_kind = 2'b00;
    logic [SLOT_W-1:0] evt_slot = '0;
    logic [SLOTS-1:0]  fixed_mask = 32'h0000_0005;
    logic              io_wr = 1'b0;
    logic [ADDR_W-1:0] io_addr = '0;
    logic [SLOTS-1:0]  io_wdata = '0;
    logic [SLOTS-1:0]  io_rdata;
    logic              gpe_pending;
    logic              eject_pulse;
    logic [SLOT_W-1:0] eject_slot;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hp_event_ctrl u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_wdata = '0;
    endtask

    task automatic io_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        io_addr = a;
        #1 d = io_rdata;
    endtask

    task automatic send_evt(input logic [1:0] k, input int s);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = k; evt_slot = SLOT_W'(s);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        io_read(A_STS_LO, d); check("R1 sts lo", d, 0);
        io_read(A_EN_LO, d);  check("R1 en lo", d, 0);
        io_read(A_INS, d);    check("R1 ins", d, 0);
        io_read(A_REM, d);    check("R1 rem", d, 0);
        check("R1 pending", gpe_pending, 0);
        check("R1 eject", eject_pulse, 0);
    endtask

    task automatic t_enable_bytes;
        logic [31:0] d;
        io_write(A_EN_LO, 32'hFFFF_FF5A);
        io_write(A_EN_HI, 32'h0000_00C3);
        io_read(A_EN_LO, d); check("R2 R3 en lo", d, 32'h5A);
        io_read(A_EN_HI, d); check("R3 en hi", d, 32'hC3);
        io_write(A_EN_LO, 32'h0000_0002);
        io_read(A_EN_HI, d); check("R3 hi untouched", d, 32'hC3);
        io_read(A_EN_LO, d); check("R3 lo replaced", d, 32'h02);
    endtask

    task automatic t_insert_remove;
        logic [31:0] d;
        send_evt(2'b01, 31);
        io_read(A_INS, d); check("R5 ins slot31", d, 32'h8000_0000);
        io_read(A_STS_LO, d); check("R5 sts bit1", d, 32'h02);
        check("R8 pending on", gpe_pending, 1);
        send_evt(2'b10, 0);
        io_read(A_REM, d); check("R6 rem slot0", d, 32'h1);
        io_read(A_INS, d); check("R6 ins wiped", d, 0);
        send_evt(2'b01, 13);
        io_read(A_REM, d); check("R5 rem wiped", d, 0);
        io_read(A_INS, d); check("R5 ins slot13", d, 32'h0000_2000);
    endtask

    task automatic t_status_clear;
        logic [31:0] d;
        io_write(A_STS_LO, 32'h0000_00FD);
        io_read(A_STS_LO, d); check("R4 unset mask keeps", d, 32'h02);
        io_write(A_STS_HI, 32'h0000_00FF);
        io_read(A_STS_LO, d); check("R4 other byte kept", d, 32'h02);
        io_write(A_STS_LO, 32'h0000_0002);
        io_read(A_STS_LO, d); check("R4 cleared", d, 0);
        check("R8 pending off", gpe_pending, 0);
    endtask

    task automatic t_cold;
        logic [31:0] d;
        send_evt(2'b00, 7);
        send_evt(2'b11, 9);
        io_read(A_INS, d); check("R7 ins kept", d, 32'h0000_2000);
        io_read(A_STS_LO, d); check("R7 no status", d, 0);
    endtask

    task automatic t_pending_enable;
        send_evt(2'b10, 4);
        check("R8 pending", gpe_pending, 1);
        io_write(A_EN_LO, 32'h0);
        check("R8 disabled", gpe_pending, 0);
        io_write(A_EN_LO, 32'h2);
        check("R8 reenabled", gpe_pending, 1);
        io_write(A_STS_LO, 32'h2);
    endtask

    task automatic t_sw_regs;
        logic [31:0] d;
        io_write(A_INS, 32'hDEAD_BEEF);
        io_write(A_REM, 32'h1234_5678);
        io_read(A_INS, d); check("R9 ins rw", d, 32'hDEAD_BEEF);
        io_read(A_REM, d); check("R9 rem rw", d, 32'h1234_5678);
    endtask

    task automatic t_eject;
        logic [31:0] d;
        io_write(A_EJECT, 32'h0000_0050);
        check("R10 pulse", eject_pulse, 1);
        check("R10 slot lowest", eject_slot, 4);
        @(negedge clk);
        check("R10 one cycle", eject_pulse, 0);
        io_write(A_EJECT, 32'h8000_0000);
        check("R10 slot31", eject_slot, 31);
        io_write(A_EJECT, 32'h0);
        check("R10 zero no pulse", eject_pulse, 0);
        io_read(A_EJECT, d); check("R10 read zero", d, 0);
    endtask

    task automatic t_removable;
        logic [31:0] d;
        io_read(A_RMV, d); check("R11 mask", d, 32'hFFFF_FFFA);
        io_write(A_RMV, 32'h0);
        io_read(A_RMV, d); check("R11 write ignored", d, 32'hFFFF_FFFA);
        fixed_mask = 32'h8000_0000;
        io_read(A_RMV, d); check("R11 follows mask", d, 32'h7FFF_FFFF);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = 2'b01; evt_slot = 5'd9;
        io_wr = 1'b1; io_addr = A_INS; io_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        evt_valid = 1'b0;
        io_addr = A_STS_LO; io_wdata = 32'h2;
        @(negedge clk);
        evt_valid = 1'b0; io_wr = 1'b0;
        io_read(A_INS, d); check("R12 event wins", d, 32'h0000_0200);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = 2'b10; evt_slot = 5'd1;
        io_wr = 1'b1; io_addr = A_STS_LO; io_wdata = 32'h2;
        @(negedge clk);
        evt_valid = 1'b0; io_wr = 1'b0;
        io_read(A_STS_LO, d); check("R12 set beats clear", d, 32'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_bytes();
        t_insert_remove();
        t_status_clear();
        t_cold();
        t_pending_enable();
        t_sw_regs();
        t_eject();
        t_removable();
        t_collision();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule